// File: doc/BRIEF.md
# Sized Little-Endian Data Memory

This block is the byte-addressed data store of a small microcontroller core. Each request presents a base address, an index and an access size of 8, 16 or 32 bits. The block scales the index by the access width in bytes and adds it to the base, then loads or stores at the resulting effective address. Wider values are kept in little-endian byte order.

Misaligned accesses are neither trapped nor split into smaller accesses. A misaligned load quietly rounds its address down to the access width. A misaligned store writes a fixed, corrupted pattern into the aligned container. Software that keeps its accesses aligned never sees these effects, but the core depends on the corrupted patterns being exact and repeatable.

The block has one request port, and a request is accepted whenever `req_valid` is high. A store updates the memory on the clock edge that accepts it. A load answers on the following cycle with `rsp_valid`. Internally the response path is a two-state machine:
- **RSP_IDLE** means no load is in flight.
- **RSP_LOAD** means load data is on `rsp_rdata` this cycle.

The machine moves between these states through four transitions:
- **T_ISSUE** (RSP_IDLE to RSP_LOAD): a load is accepted.
- **T_CHAIN** (RSP_LOAD to RSP_LOAD): another load is accepted back to back.
- **T_DRAIN** (RSP_LOAD to RSP_IDLE): a store is accepted, or no request is presented.
- **T_REST** (RSP_IDLE to RSP_IDLE): a store is accepted, or no request is presented.

Top module: `lsm_data_mem`

## Requirements
- R1: The size code `req_size` selects the access width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, and 3 also behaves as 32-bit. The effective address is `req_base + req_idx * (1, 2 or 4)`, computed in 32 bits. Only its low log2(MEM_BYTES) bits select a byte, so addresses wrap modulo MEM_BYTES.
- R2: Byte order is little-endian: the byte at the lowest address is bits 7:0 of a 16- or 32-bit value.
- R3: A 32-bit load ignores address bits 1:0. A 16-bit load ignores address bit 0 and returns its halfword in bits 15:0, with bits 31:16 zero.
- R4: A byte load or store uses the exact effective address. A byte load returns its byte in bits 7:0, with bits 31:8 zero.
- R5: A 32-bit store whose address has bit 0 set writes the whole aligned word. Byte (address mod 4) of that word receives `req_wdata[7:0]`, and the other three bytes become zero.
- R6: A 32-bit store whose address ends in binary 10 writes the aligned word as `{req_wdata[15:0], 16'h0000}`.
- R7: A 16-bit store to an odd address writes the aligned halfword. Its upper byte receives `req_wdata[7:0]` and its lower byte becomes zero. The other halfword of the word is unchanged.
- R8: An aligned store, and every byte store, changes only the bytes it addresses. All other bytes keep their contents.
- R9: `rsp_valid` is low after reset. It is high in exactly the cycle after each accepted load and low after any other cycle. While `rsp_valid` is low, `rsp_rdata` is zero.
- R10: A store takes effect on its accepting edge, so a load accepted in the very next cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response logic |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0 = 8, 1 = 16, 2 or 3 = 32 bits) |
| req_base | input | 32 | Base address |
| req_idx | input | 32 | Index, scaled by the access size in bytes |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid (one cycle after the load request) |
| rsp_rdata | output | 32 | Load data, zero-extended; zero when not valid |

## Verification
The penalty paths are the hardest behaviour to reach and to observe. A misaligned effective address has to arise from a base plus a scaled index, and the zeroed bytes are visible only if those bytes held non-zero data beforehand. The stimulus therefore first fills every word with a pattern whose bytes are all non-zero. It then mixes random 32-bit bases with small random indices, so every address offset occurs under every size. Directed misaligned stores are each followed by whole-word and neighbouring-byte loads, which expose both the mangled lanes and the lanes that must stay untouched.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    // Access size code as presented on req_size.
    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } acc_size_e;

    // Response state machine.
    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_LOAD = 1'b1
    } rsp_state_e;

    localparam int LANES      = 4;
    localparam int LANE_BITS  = 8;
    localparam int WORD_BITS  = LANES * LANE_BITS;

    // log2 of the access width in bytes.
    function automatic logic [1:0] size_shift(input acc_size_e s);
        logic [1:0] r;
        unique case (s)
            SZ_BYTE: r = 2'd0;
            SZ_HALF: r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

    function automatic logic is_word(input acc_size_e s);
        return (s == SZ_WORD) || (s == SZ_WORD_ALT);
    endfunction

endpackage

// File: rtl/lsm_agen.sv
module lsm_agen #(
    parameter int AW = 10
) (
    input  logic [31:0]           base,
    input  logic [31:0]           idx,
    input  lsm_pkg::acc_size_e    size,
    output logic [AW-1:0]         ea
);
    import lsm_pkg::*;

    logic [31:0] scaled;
    logic [31:0] sum;
    logic        unused_sum_hi;

    // Index scaled by access width, then added to the base in full width.
    always_comb begin
        scaled = idx << size_shift(size);
        sum    = base + scaled;
    end

    // Bits above the memory span carry no meaning.
    assign ea            = sum[AW-1:0];
    assign unused_sum_hi = ^sum[31:AW];

endmodule

// File: rtl/lsm_store_fmt.sv
module lsm_store_fmt (
    input  lsm_pkg::acc_size_e size,
    input  logic [1:0]         off,
    input  logic [31:0]        wdata,
    output logic [3:0]         be,
    output logic [31:0]        lane_data
);
    import lsm_pkg::*;

    logic [15:0] half_val;

    always_comb begin
        be        = 4'b0000;
        lane_data = 32'h0;
        half_val  = 16'h0;
        if (is_word(size)) begin
            // Whole aligned word is always rewritten.
            be = 4'b1111;
            if (off[0]) begin
                lane_data = {24'h0, wdata[7:0]} << {off, 3'b000};
            end else if (off[1]) begin
                lane_data = {wdata[15:0], 16'h0};
            end else begin
                lane_data = wdata;
            end
        end else if (size == SZ_HALF) begin
            be        = off[1] ? 4'b1100 : 4'b0011;
            half_val  = off[0] ? {wdata[7:0], 8'h00} : wdata[15:0];
            lane_data = {half_val, half_val};
        end else begin
            be        = 4'b0001 << off;
            lane_data = {4{wdata[7:0]}};
        end
    end

endmodule

// File: rtl/lsm_bank.sv
module lsm_bank #(
    parameter int ROWS = 256,
    parameter int RW   = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [RW-1:0] row,
    input  logic [3:0]    be,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    import lsm_pkg::*;

    // One byte-wide array per lane; lane g holds byte (addr mod 4) == g.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_BITS-1:0] cell_q [ROWS];
        logic [LANE_BITS-1:0] out_q;

        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                cell_q[row] <= wdata[g*LANE_BITS +: LANE_BITS];
            end
            if (re) begin
                out_q <= cell_q[row];
            end
        end

        assign rdata[g*LANE_BITS +: LANE_BITS] = out_q;
    end

endmodule

// File: rtl/lsm_load_fmt.sv
module lsm_load_fmt (
    input  logic               en,
    input  lsm_pkg::acc_size_e size,
    input  logic [1:0]         off,
    input  logic [31:0]        word,
    output logic [31:0]        data
);
    import lsm_pkg::*;

    always_comb begin
        data = 32'h0;
        if (en) begin
            if (is_word(size)) begin
                data = word;
            end else if (size == SZ_HALF) begin
                data = off[1] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
            end else begin
                data = {24'h0, word[{off, 3'b000} +: 8]};
            end
        end
    end

endmodule

// File: rtl/lsm_data_mem.sv
module lsm_data_mem #(
    parameter int MEM_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_base,
    input  logic [31:0] req_idx,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    import lsm_pkg::*;

    localparam int AW   = $clog2(MEM_BYTES);
    localparam int RW   = AW - 2;
    localparam int ROWS = MEM_BYTES / LANES;

    acc_size_e  sz;
    logic [AW-1:0] ea;
    logic [3:0] st_be;
    logic [31:0] st_data;
    logic [31:0] bank_word;
    logic       load_req;
    logic       store_req;

    rsp_state_e state_q, state_d;
    acc_size_e  rd_size_q;
    logic [1:0] rd_off_q;

    assign sz        = acc_size_e'(req_size);
    assign load_req  = req_valid && !req_write;
    assign store_req = req_valid &&  req_write;

    lsm_agen #(.AW(AW)) u_agen (
        .base (req_base),
        .idx  (req_idx),
        .size (sz),
        .ea   (ea)
    );

    lsm_store_fmt u_stfmt (
        .size      (sz),
        .off       (ea[1:0]),
        .wdata     (req_wdata),
        .be        (st_be),
        .lane_data (st_data)
    );

    lsm_bank #(.ROWS(ROWS), .RW(RW)) u_bank (
        .clk   (clk),
        .we    (store_req),
        .re    (load_req),
        .row   (ea[AW-1:2]),
        .be    (st_be),
        .wdata (st_data),
        .rdata (bank_word)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RSP_IDLE;
            rd_size_q <= SZ_BYTE;
            rd_off_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if (load_req) begin
                rd_size_q <= sz;
                rd_off_q  <= ea[1:0];
            end
        end
    end

    // Next state: T_ISSUE / T_CHAIN on a load, T_DRAIN / T_REST otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = load_req ? RSP_LOAD : RSP_IDLE;
            RSP_LOAD: state_d = load_req ? RSP_LOAD : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        rsp_valid = (state_q == RSP_LOAD);
    end

    lsm_load_fmt u_ldfmt (
        .en   (rsp_valid),
        .size (rd_size_q),
        .off  (rd_off_q),
        .word (bank_word),
        .data (rsp_rdata)
    );

    // Response timing.
    AST_LOAD_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req |=> !rsp_valid); // R9
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == 32'h0)); // R9

    // Zero extension of narrow loads.
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rd_size_q == SZ_BYTE) |-> (rsp_rdata[31:8] == 24'h0)); // R4
    AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rd_size_q == SZ_HALF) |-> (rsp_rdata[31:16] == 16'h0)); // R3

    // Store lane selection and penalty patterns.
    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> ($countones(st_be) ==
            ((sz == SZ_BYTE) ? 1 : (sz == SZ_HALF) ? 2 : 4))); // R8
    AST_ODD_WORD_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && is_word(sz) && ea[0]) |-> ($countones(st_data) ==
            $countones(req_wdata[7:0]))); // R5
    AST_HALFWORD_OFF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && is_word(sz) && ea[1:0] == 2'b10) |-> (st_data[15:0] == 16'h0)); // R6
    AST_ODD_HALF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && sz == SZ_HALF && ea[0]) |-> (st_data[{ea[1], 4'b0000} +: 8] == 8'h0)); // R7

endmodule

// File: tb/tb_lsm_data_mem.sv
`timescale 1ns/1ps
module tb_lsm_data_mem;

    localparam int MEM_BYTES = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_base = 32'h0;
    logic [31:0] req_idx = 32'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [MEM_BYTES];

    always #4 clk = ~clk;

    lsm_data_mem #(.MEM_BYTES(MEM_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_base(req_base), .req_idx(req_idx),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned eff(input logic [31:0] b, input logic [31:0] ix, input logic [1:0] sz);
        logic [31:0] s;
        s = b + (ix << ((sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2));
        return s & (MEM_BYTES - 1);
    endfunction

    function automatic logic [31:0] mload(input logic [1:0] sz, input int unsigned a);
        int unsigned w;
        if (sz == 2'd0) return {24'h0, model[a]};
        if (sz == 2'd1) begin
            w = a & ~32'd1;
            return {16'h0, model[w+1], model[w]};
        end
        w = a & ~32'd3;
        return {model[w+3], model[w+2], model[w+1], model[w]};
    endfunction

    task automatic mstore(input logic [1:0] sz, input int unsigned a, input logic [31:0] wd);
        int unsigned w;
        logic [31:0] v;
        if (sz == 2'd0) begin
            model[a] = wd[7:0];
        end else if (sz == 2'd1) begin
            w = a & ~32'd1;
            v = a[0] ? {16'h0, wd[7:0], 8'h00} : wd;
            model[w] = v[7:0];
            model[w+1] = v[15:8];
        end else begin
            w = a & ~32'd3;
            if (a[0]) v = {24'h0, wd[7:0]} << (8 * (a & 3));
            else if (a[1]) v = {wd[15:0], 16'h0};
            else v = wd;
            for (int k = 0; k < 4; k++) model[w+k] = v[k*8 +: 8];
        end
    endtask

    task automatic op(input bit wr, input logic [1:0] sz, input logic [31:0] b,
                      input logic [31:0] ix, input logic [31:0] wd, input string tag);
        int unsigned a;
        logic [31:0] exp;
        a = eff(b, ix, sz);
        exp = 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_base = b; req_idx = ix; req_wdata = wd;
        if (wr) mstore(sz, a, wd);
        else exp = mload(sz, a);
        @(posedge clk);
        #2;
        if (wr) check(!rsp_valid, {tag, " store gives no response (R9)"}, {31'h0, rsp_valid}, 32'h0);
        else check(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #2;
        check(!rsp_valid && rsp_rdata == 32'h0, "R9 idle", rsp_rdata, 32'h0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rb, ri, rw;
        logic [1:0] rs;
        bit wr;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        check(!rsp_valid && rsp_rdata == 32'h0, "R9 reset", rsp_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill every word with all-nonzero bytes.
        for (int i = 0; i < MEM_BYTES / 4; i++)
            op(1'b1, 2'd2, 32'h0, i, 32'h80808080 | (i * 32'h01030507), "R8 fill");

        // Little-endian order and index scaling.
        op(1'b1, 2'd2, 32'd16, 32'd0, 32'h11223344, "R2 store");
        op(1'b0, 2'd0, 32'd16, 32'd0, 32'h0, "R2 byte0");
        op(1'b0, 2'd0, 32'd16, 32'd3, 32'h0, "R2 byte3");
        op(1'b0, 2'd1, 32'd16, 32'd1, 32'h0, "R2 upper half");
        op(1'b0, 2'd2, 32'd8, 32'd2, 32'h0, "R1 scaled word index");
        op(1'b0, 2'd2, MEM_BYTES + 16, 32'd0, 32'h0, "R1 wrap");
        op(1'b0, 2'd1, 32'hFFFF_FFF0, 32'd8, 32'h0, "R1 wrap with half index");

        // Misaligned word stores.
        op(1'b1, 2'd2, 32'd33, 32'd0, 32'hDEADBEEF, "R5 store off1");
        op(1'b0, 2'd2, 32'd32, 32'd0, 32'h0, "R5 read off1");
        op(1'b1, 2'd2, 32'd35, 32'd0, 32'hDEADBEEF, "R5 store off3");
        op(1'b0, 2'd2, 32'd32, 32'd0, 32'h0, "R5 read off3");
        op(1'b1, 2'd2, 32'd42, 32'd0, 32'hCAFEBABE, "R6 store off2");
        op(1'b0, 2'd2, 32'd40, 32'd0, 32'h0, "R6 read");
        op(1'b0, 2'd2, 32'd43, 32'd0, 32'h0, "R3 misaligned word load");

        // Misaligned halfword store; neighbour halfword untouched.
        op(1'b1, 2'd1, 32'd49, 32'd0, 32'h00001234, "R7 store odd half");
        op(1'b0, 2'd1, 32'd48, 32'd0, 32'h0, "R7 read half");
        op(1'b0, 2'd1, 32'd51, 32'd0, 32'h0, "R7 other half kept");
        op(1'b0, 2'd2, 32'd48, 32'd0, 32'h0, "R7 word view");

        // Byte stores touch a single byte; code 3 acts as word.
        op(1'b1, 2'd0, 32'd61, 32'd0, 32'hFFFFFF5A, "R4 byte store");
        op(1'b0, 2'd2, 32'd60, 32'd0, 32'h0, "R8 byte neighbours");
        op(1'b1, 2'd3, 32'd64, 32'd0, 32'h01020304, "R1 size code 3 store");
        op(1'b0, 2'd3, 32'd64, 32'd0, 32'h0, "R1 size code 3 load");
        op(1'b0, 2'd2, 32'd64, 32'd0, 32'h0, "R10 load right after store");
        idle_check();

        // Random mix.
        for (int n = 0; n < 4000; n++) begin
            wr = $urandom_range(0, 1);
            rs = 2'($urandom_range(0, 3));
            rb = $urandom;
            ri = ($urandom_range(0, 7) == 0) ? $urandom : $urandom_range(0, 15);
            rw = $urandom;
            if (wr) op(1'b1, rs, rb, ri, rw, "R8 random store");
            else if (rs == 2'd0) op(1'b0, rs, rb, ri, rw, "R4 random byte load");
            else op(1'b0, rs, rb, ri, rw, "R3 random load");
            if ($urandom_range(0, 15) == 0) idle_check();
        end
        idle_check();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule